// File: doc/BRIEF.md
# Accumulator readout with rounding and clamping

This block turns the 64-bit contents of a multiply-accumulate accumulator into a 32-bit register value. A two-bit mode code picks signed-integer, unsigned-integer or fractional interpretation. In the fractional interpretation, three further controls apply. One selects a 16-bit result, which is always rounded at bit 24. One enables round-to-nearest-even at bit 8 for the 32-bit result. One clamps an out-of-range result to the largest value of its sign. In integer modes an out-of-range accumulator is always clamped.

The caller presents the accumulator word and the mode controls together with `in_valid`. One clock edge later the result appears on `res_out` with a one-cycle `res_valid` strobe. A small two-state machine drives the strobe. In `ST_IDLE` no result is being presented. In `ST_EMIT` a result captured on the previous edge is on the output. The transitions are:
- accept: `ST_IDLE` to `ST_EMIT` when `in_valid` is high.
- stream: `ST_EMIT` to `ST_EMIT` when `in_valid` stays high.
- drain: `ST_EMIT` to `ST_IDLE` when `in_valid` is low.

Top module: `macrd_readout`

## Requirements
- R1: After reset `res_valid` and `res_out` are 0. Each cycle with `in_valid` high produces `res_valid` high on the next cycle. A cycle without `in_valid` produces `res_valid` low on the next cycle, and `res_out` holds its value.
- R2: In signed-integer mode (`mode_sel`=00), an accumulator that fits in a signed 32-bit word is returned as its low 32 bits.
- R3: In signed-integer mode, an out-of-range accumulator gives 0x7FFFFFFF if bit 63 is 0 and 0x80000000 if bit 63 is 1.
- R4: In unsigned-integer mode (`mode_sel`=01), the low 32 bits are returned when bits 63:32 are zero. Otherwise the result is 0xFFFFFFFF.
- R5: In fractional mode with 32-bit output and `round_en`=0, the result comes from the accumulator arithmetically shifted right by 8. The discarded bits are ignored.
- R6: In fractional mode with 32-bit output and `round_en`=1, the shifted value is incremented when the low 8 bits exceed 0x80. When the low 8 bits equal 0x80, the shifted value is incremented only if its LSB is 1.
- R7: In fractional mode with `half_out`=1, the value is the accumulator arithmetically shifted right by 24. It is rounded to nearest even with 0x800000 as the half point, whatever `round_en` is. The 16-bit result sits in bits 15:0 and bits 31:16 are 0.
- R8: In fractional mode with `sat_en`=0, the low 16 or low 32 bits of the rounded value are returned unchanged, even when the value is out of range.
- R9: In fractional mode with `half_out`=1 and `sat_en`=1, a rounded value outside the signed 16-bit range gives 0x7FFF if positive and 0x8000 if negative.
- R10: In fractional mode with 32-bit output and `sat_en`=1, a rounded value outside the signed 32-bit range gives 0x7FFFFFFF if positive and 0x80000000 if negative.
- R11: An all-zero accumulator in fractional mode gives a result of 0 under every combination of controls.
- R12: Mode code 11 behaves exactly like code 10 (fractional).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Accumulator word and controls are valid this cycle |
| acc_in | input | 64 | Accumulator contents |
| mode_sel | input | 2 | 00 signed integer, 01 unsigned integer, 1x fractional |
| half_out | input | 1 | Fractional: 16-bit result rounded at bit 24 |
| round_en | input | 1 | Fractional 32-bit: round to nearest even at bit 8 |
| sat_en | input | 1 | Fractional: clamp out-of-range results |
| res_valid | output | 1 | One-cycle strobe marking a new result |
| res_out | output | 32 | Registered result |

## Verification
The assertions assume that the mode controls are sampled only in cycles where `in_valid` is high. They also assume that the controls may change freely between such cycles. The overflow properties assume that a positive accumulator with any of bits 62:39 set is out of range in both fractional widths, since rounding only moves a value upward. The bench drives every input on the falling edge and holds it for exactly one rising edge. It keeps `in_valid` low between scenarios, so each result is attributed to a single accepted word.

// File: rtl/macrd_pkg.sv
package macrd_pkg;
    localparam int ACC_W   = 64;
    localparam int RES_W   = 32;
    localparam int HALF_W  = 16;
    localparam int FULL_SH = 8;
    localparam int HALF_SH = 24;

    typedef enum logic [1:0] {
        MODE_SINT     = 2'b00,
        MODE_UINT     = 2'b01,
        MODE_FRAC     = 2'b10,
        MODE_FRAC_ALT = 2'b11
    } mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } state_e;
endpackage

// File: rtl/macrd_round.sv
module macrd_round #(
    parameter int W  = 64,
    parameter int SH = 8
) (
    input  logic [W-1:0]  acc,
    input  logic          en,
    output logic [W-SH:0] q
);
    localparam int QW = W - SH + 1;
    localparam logic [SH-1:0] HALFP = {1'b1, {(SH-1){1'b0}}};

    logic [QW-2:0] base;
    logic [SH-1:0] rem;
    logic          inc;

    always_comb begin
        base = acc[W-1:SH];
        rem  = acc[SH-1:0];
        inc  = en && ((rem > HALFP) || ((rem == HALFP) && base[0]));
        q    = {base[QW-2], base} + QW'(inc);
    end
endmodule

// File: rtl/macrd_clip.sv
module macrd_clip #(
    parameter int IW = 64,
    parameter int OW = 32
) (
    input  logic [IW-1:0] din,
    input  logic          sat,
    output logic [OW-1:0] dout
);
    logic fits;

    always_comb begin
        fits = (&din[IW-1:OW-1]) || ~(|din[IW-1:OW-1]);
        if (sat && !fits)
            dout = din[IW-1] ? {1'b1, {(OW-1){1'b0}}} : {1'b0, {(OW-1){1'b1}}};
        else
            dout = din[OW-1:0];
    end
endmodule

// File: rtl/macrd_readout.sv
module macrd_readout
    import macrd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [ACC_W-1:0]     acc_in,
    input  logic [1:0]           mode_sel,
    input  logic                 half_out,
    input  logic                 round_en,
    input  logic                 sat_en,
    output logic                 res_valid,
    output logic [RES_W-1:0]     res_out
);
    localparam int QH_W = ACC_W - HALF_SH + 1;
    localparam int QF_W = ACC_W - FULL_SH + 1;

    state_e               state_q;
    logic [QH_W-1:0]      q_half;
    logic [QF_W-1:0]      q_full;
    logic [HALF_W-1:0]    r_half;
    logic [RES_W-1:0]     r_full;
    logic [RES_W-1:0]     r_sint;
    logic [RES_W-1:0]     r_uint;
    logic [RES_W-1:0]     res_next;

    macrd_round #(.W(ACC_W), .SH(HALF_SH)) i_round_half (
        .acc (acc_in), .en (1'b1), .q (q_half)
    );

    macrd_round #(.W(ACC_W), .SH(FULL_SH)) i_round_full (
        .acc (acc_in), .en (round_en), .q (q_full)
    );

    macrd_clip #(.IW(QH_W), .OW(HALF_W)) i_clip_half (
        .din (q_half), .sat (sat_en), .dout (r_half)
    );

    macrd_clip #(.IW(QF_W), .OW(RES_W)) i_clip_full (
        .din (q_full), .sat (sat_en), .dout (r_full)
    );

    macrd_clip #(.IW(ACC_W), .OW(RES_W)) i_clip_sint (
        .din (acc_in), .sat (1'b1), .dout (r_sint)
    );

    always_comb begin
        r_uint = (|acc_in[ACC_W-1:RES_W]) ? {RES_W{1'b1}} : acc_in[RES_W-1:0];
        unique case (mode_e'(mode_sel))
            MODE_SINT:     res_next = r_sint;
            MODE_UINT:     res_next = r_uint;
            MODE_FRAC,
            MODE_FRAC_ALT: res_next = half_out ? {{(RES_W-HALF_W){1'b0}}, r_half} : r_full;
            default:       res_next = '0;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: state_q <= in_valid ? ST_EMIT : ST_IDLE;
                ST_EMIT: state_q <= in_valid ? ST_EMIT : ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            res_out <= '0;
        else if (in_valid)
            res_out <= res_next;
    end

    assign res_valid = (state_q == ST_EMIT);
endmodule

// File: rtl/macrd_checker.sv
module macrd_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [63:0] acc_in,
    input logic [1:0]  mode_sel,
    input logic        half_out,
    input logic        sat_en,
    input logic        res_valid,
    input logic [31:0] res_out
);
    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> res_valid);
    a_r1_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !res_valid);
    a_r1_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(res_out));
    a_r3_sint_clamp_pos: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode_sel == 2'b00 && !acc_in[63] && |acc_in[62:31])
        |=> res_out == 32'h7FFF_FFFF);
    a_r3_sint_clamp_neg: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode_sel == 2'b00 && acc_in[63] && !(&acc_in[62:31]))
        |=> res_out == 32'h8000_0000);
    a_r4_uint_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode_sel == 2'b01 && |acc_in[63:32])
        |=> res_out == 32'hFFFF_FFFF);
    a_r7_half_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode_sel[1] && half_out) |=> res_out[31:16] == 16'h0);
    a_r9_half_sat_pos: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode_sel[1] && half_out && sat_en && !acc_in[63] && |acc_in[62:39])
        |=> res_out == 32'h0000_7FFF);
    a_r10_full_sat_pos: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode_sel[1] && !half_out && sat_en && !acc_in[63] && |acc_in[62:39])
        |=> res_out == 32'h7FFF_FFFF);
    a_r11_zero_frac: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode_sel[1] && acc_in == 64'h0) |=> res_out == 32'h0);
endmodule

bind macrd_readout macrd_checker i_macrd_checker (.*);

// File: tb/test_macrd_readout.sv
module test_macrd_readout;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] acc_in = '0;
    logic [1:0]  mode_sel = '0;
    logic        half_out = 1'b0;
    logic        round_en = 1'b0;
    logic        sat_en = 1'b0;
    logic        res_valid;
    logic [31:0] res_out;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    macrd_readout i_macrd_readout (.*);

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic apply(input logic [63:0] a, input logic [1:0] m, input logic h,
                         input logic r, input logic s, input string req,
                         input logic [31:0] exp);
        @(negedge clk);
        acc_in = a; mode_sel = m; half_out = h; round_en = r; sat_en = s;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " valid"}, {31'h0, res_valid}, 32'h1);
        check(req, res_out, exp);
    endtask

    task automatic test_reset;
        check("R1 reset valid", {31'h0, res_valid}, 32'h0);
        check("R1 reset result", res_out, 32'h0);
    endtask

    task automatic test_signed;
        apply(64'hFFFF_FFFF_8000_0000, 2'b00, 0, 0, 0, "R2 min in range", 32'h8000_0000);
        apply(64'h0000_0000_7FFF_FFFF, 2'b00, 0, 0, 0, "R2 max in range", 32'h7FFF_FFFF);
        apply(64'h0000_0000_8000_0000, 2'b00, 0, 0, 0, "R3 pos overflow", 32'h7FFF_FFFF);
        apply(64'hFFFF_FFFF_7FFF_FFFF, 2'b00, 0, 0, 0, "R3 neg overflow", 32'h8000_0000);
    endtask

    task automatic test_unsigned;
        apply(64'h0000_0000_FFFF_FFFE, 2'b01, 0, 0, 0, "R4 in range", 32'hFFFF_FFFE);
        apply(64'h0000_0001_0000_0000, 2'b01, 0, 0, 0, "R4 overflow", 32'hFFFF_FFFF);
    endtask

    task automatic test_frac_full;
        apply(64'h0000_0000_1234_56FF, 2'b10, 0, 0, 0, "R5 truncate", 32'h0012_3456);
        apply(64'h0000_0000_1234_56FF, 2'b10, 0, 1, 0, "R6 round up", 32'h0012_3457);
        apply(64'h0000_0000_1234_5680, 2'b10, 0, 1, 0, "R6 tie even", 32'h0012_3456);
        apply(64'h0000_0000_1234_5780, 2'b10, 0, 1, 0, "R6 tie odd", 32'h0012_3458);
        apply(64'hFFFF_FFFF_FFFF_FF80, 2'b10, 0, 1, 0, "R6 negative tie", 32'h0000_0000);
    endtask

    task automatic test_frac_half;
        apply(64'h0000_0012_3480_0000, 2'b10, 1, 0, 0, "R7 tie even", 32'h0000_1234);
        apply(64'h0000_0012_3580_0000, 2'b10, 1, 0, 0, "R7 tie odd", 32'h0000_1236);
        apply(64'h0000_0012_3480_0001, 2'b10, 1, 1, 0, "R7 above half", 32'h0000_1235);
        apply(64'h0000_0012_357F_FFFF, 2'b11, 1, 0, 0, "R12 alt code half", 32'h0000_1235);
    endtask

    task automatic test_saturate;
        apply(64'h0000_0080_0000_0000, 2'b10, 1, 0, 0, "R8 half wrap", 32'h0000_8000);
        apply(64'h0000_0080_0000_0000, 2'b10, 1, 0, 1, "R9 half pos", 32'h0000_7FFF);
        apply(64'hFFFF_FF7F_0000_0000, 2'b10, 1, 0, 0, "R8 half neg wrap", 32'h0000_7F00);
        apply(64'hFFFF_FF7F_0000_0000, 2'b10, 1, 0, 1, "R9 half neg", 32'h0000_8000);
        apply(64'h0000_0080_0000_0000, 2'b10, 0, 0, 0, "R8 full wrap", 32'h8000_0000);
        apply(64'h0000_0080_0000_0000, 2'b10, 0, 0, 1, "R10 full pos", 32'h7FFF_FFFF);
        apply(64'hFFFF_FF7F_FFFF_FF00, 2'b10, 0, 0, 1, "R10 full neg", 32'h8000_0000);
        apply(64'h0000_007F_FFFF_FFC0, 2'b10, 0, 1, 1, "R10 round carry", 32'h7FFF_FFFF);
        apply(64'h0000_0080_0000_0000, 2'b11, 0, 0, 1, "R12 alt code full", 32'h7FFF_FFFF);
    endtask

    task automatic test_zero;
        apply(64'h0000_0001_2345_6789, 2'b01, 0, 0, 0, "R11 preload", 32'hFFFF_FFFF);
        apply(64'h0, 2'b10, 0, 1, 1, "R11 zero full", 32'h0);
        apply(64'h0, 2'b10, 1, 1, 0, "R11 zero half", 32'h0);
        apply(64'h0, 2'b11, 0, 0, 0, "R11 zero alt", 32'h0);
    endtask

    task automatic test_pulse;
        apply(64'h0000_0000_0000_1234, 2'b00, 0, 0, 0, "R1 pulse load", 32'h0000_1234);
        acc_in = 64'h0000_0000_0000_5678;
        @(negedge clk);
        check("R1 strobe low", {31'h0, res_valid}, 32'h0);
        check("R1 result held", res_out, 32'h0000_1234);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset;
        rst_n = 1'b1;
        test_reset;
        test_signed;
        test_unsigned;
        test_frac_full;
        test_frac_half;
        test_saturate;
        test_zero;
        test_pulse;
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule